// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Interface

This block is the digital front end of a two-channel 16-bit voltage-output converter. A host shifts 24-bit words into it over a three-wire serial link: an active-low frame line, a serial clock and a data line. Each word is decoded into a read/write flag, a three-bit register selector, a channel field and a 16-bit payload. Writes update a per-channel input register, a per-channel six-bit gain trim or a small shared control register. A second register stage per channel holds the code that is actually presented to the converter core. It is refreshed from the input stage while the load line is low, or forced to a clear code while the clear line is high.

A read word names one register, and that register's contents come back on the serial output during the following frame. With chain mode on, the serial output instead repeats the input stream 24 serial clocks late, so several devices can share one frame line and one clock. A coding input selects whether payload codes are offset binary or two's complement. The converter core always receives offset binary. All serial lines are sampled with the system clock, so the serial clock must be several system clocks slower.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both core codes read 0x8000, both gain trims read 0, the control bits read 0 and ser_dout is low; the data registers hold the 0 V code of the coding selected during reset (0x8000 offset binary, 0x0000 two's complement).
- R2: A frame is taken only when exactly 24 rising ser_clk edges occur while ser_frame_n is low, with the first bit being bit 23; a frame of any other length changes no register.
- R3: Frame layout: bit 23 is 1 for read and 0 for write, bits 22:20 select the register (000 control, 010 data, 100 gain trim, any other value has no effect), bit 19 is unused, bits 18:16 pick the channel (000 channel 0, 001 channel 1, 1xx both), bits 15:0 are the payload.
- R4: While load_n is low, a data write reaches the addressed channel's core code without further action; releasing a clear with load_n low returns the core code to the input register.
- R5: While load_n is high, a data write leaves core_code unchanged; driving load_n low then moves the input register onto the core code.
- R6: A gain write stores payload bits 5:0 in the addressed channel's slice of gain_trim.
- R7: A control write (selector 000, channel field 001) stores payload bit 0 as ground-offset enable (driven on gnd_adj_en), bit 1 as chain mode and bit 2 as clear select; other channel values under selector 000 have no effect.
- R8: After a read frame, the next frame returns on ser_dout, MSB first and valid before each rising ser_clk, the request's bits 23:16 followed by 16 value bits: the input register for data, the gain sign-extended to 16 bits for gain, and the three control bits zero-extended for control.
- R9: In chain mode, with no readback pending, ser_dout repeats the bit taken 24 rising edges earlier, and a frame of 24 or more edges is taken using its last 24 bits; with neither chain mode nor a readback active, ser_dout stays low.
- R10: With twos_sel high the payload MSB is inverted before it reaches core_code; with twos_sel low the code passes unchanged.
- R11: While clear_req is high both core codes show the clear code: 0x8000 when clear select is 0 and 0x0000 when it is 1, in either coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_frame_n | input | 1 | Active-low frame line |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial data out: readback or chained stream |
| load_n | input | 1 | Active-low output load |
| clear_req | input | 1 | Forces the clear code while high |
| twos_sel | input | 1 | 1 = two's-complement payload, 0 = offset binary |
| core_code | output | NCH*16 | Offset-binary code per channel, channel 0 in the low bits |
| gain_trim | output | NCH*GAIN_W | Gain trim per channel, channel 0 in the low bits |
| gnd_adj_en | output | 1 | Ground-offset adjust enable |

## Verification
The data path is exercised with single-channel writes to each channel, a broadcast write, and writes under held and released load, so that addressing errors, lost broadcasts and a stuck or transparent second stage each show up as a different mismatch. Frames of 23 and 25 bits, and of 48 bits with chain mode on, separate the length rule from the last-24-bits rule. Readback of each register kind checks header echo, sign extension and channel choice. Coding is tested with 0x0000 and 0x7FFF in two's complement and with a reset taken while two's complement is selected, and both clear codes are tested so that the select bit and the return to normal output are each visible.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 16;

  localparam logic [2:0] SEL_FUNC = 3'b000;
  localparam logic [2:0] SEL_DATA = 3'b010;
  localparam logic [2:0] SEL_GAIN = 3'b100;
  localparam logic [2:0] FUNC_CTL = 3'b001;

  typedef struct packed {
    logic              rd;
    logic [2:0]        sel;
    logic              rsv;
    logic              bcast;
    logic [1:0]        chan;
    logic [CODE_W-1:0] payload;
  } frame_t;
endpackage

// File: rtl/dacif_rx.sv
module dacif_rx
  import dacif_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk,
  input  logic          ser_frame_n,
  input  logic          ser_din,
  input  logic          daisy_en,
  input  logic          rd_req,
  input  logic [FW-1:0] rd_word,
  output logic          frm_start,
  output logic          frm_commit,
  output logic [FW-1:0] frm_word,
  output logic          ser_dout
);
  localparam int CNT_W = $clog2(2 * FW);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FW  = CNT_W'(FW);

  logic [1:0]       sck_q;
  logic [1:0]       frm_q;
  logic             din_q;
  logic [FW-1:0]    in_sr;
  logic [FW-1:0]    out_sr;
  logic [CNT_W-1:0] cnt;
  logic             rd_act;
  logic             dout_q;
  logic             rise, active, stop, shift, len_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      frm_q <= 2'b11;
      din_q <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], ser_clk};
      frm_q <= {frm_q[0], ser_frame_n};
      din_q <= ser_din;
    end
  end

  assign rise      = sck_q[0] & ~sck_q[1];
  assign active    = ~frm_q[0];
  assign frm_start = ~frm_q[0] & frm_q[1];
  assign stop      = frm_q[0] & ~frm_q[1];
  assign shift     = rise & active;
  assign len_ok    = (cnt == CNT_FW) || (daisy_en && (cnt > CNT_FW));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sr <= '0;
      cnt   <= '0;
    end else begin
      if (shift) in_sr <= {in_sr[FW-2:0], din_q};
      if (frm_start) cnt <= '0;
      else if (shift && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_commit <= 1'b0;
      frm_word   <= '0;
    end else begin
      frm_commit <= stop && len_ok;
      if (stop) frm_word <= in_sr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act <= 1'b0;
      out_sr <= '0;
      dout_q <= 1'b0;
    end else begin
      if (frm_start && rd_req) begin
        rd_act <= 1'b1;
        out_sr <= rd_word;
      end else begin
        if (stop) rd_act <= 1'b0;
        if (shift && rd_act) out_sr <= {out_sr[FW-2:0], 1'b0};
      end
      dout_q <= rd_act ? out_sr[FW-1] : (daisy_en & in_sr[FW-1]);
    end
  end

  assign ser_dout = dout_q;
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int GAIN_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     twos_q,
  input  logic                     load_q,
  input  logic                     clear_q,
  input  logic                     frm_start,
  input  logic                     frm_commit,
  input  logic [FRAME_W-1:0]       frm_word,
  output logic [NCH*CODE_W-1:0]    dac_flat,
  output logic [NCH*GAIN_W-1:0]    gain_flat,
  output logic [2:0]               fn_bits,
  output logic                     rd_req,
  output logic [FRAME_W-1:0]       rd_word
);
  localparam int HDR_W = FRAME_W - CODE_W;

  frame_t                  f;
  logic                    wr_en;
  logic [NCH*CODE_W-1:0]   inp_flat;
  logic [CODE_W-1:0]       zero_code, clr_code, rd_val;
  logic [HDR_W-1:0]        rd_hdr;
  logic [2:0]              rd_sel;
  logic [1:0]              rd_ch;

  assign f         = frm_word;
  assign wr_en     = frm_commit && !f.rd;
  assign zero_code = {~twos_q, {(CODE_W-1){1'b0}}};
  assign clr_code  = {twos_q ^ ~fn_bits[2], {(CODE_W-1){1'b0}}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] inp_q, dac_q;
    logic [GAIN_W-1:0] gn_q;

    assign hit = f.bcast || (f.chan == 2'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        inp_q <= zero_code;
        gn_q  <= '0;
      end else if (wr_en && hit) begin
        if (f.sel == SEL_DATA) inp_q <= f.payload;
        if (f.sel == SEL_GAIN) gn_q  <= f.payload[GAIN_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          dac_q <= zero_code;
      else if (clear_q) dac_q <= clr_code;
      else if (!load_q) dac_q <= inp_q;
    end

    assign inp_flat[c*CODE_W +: CODE_W]  = inp_q;
    assign dac_flat[c*CODE_W +: CODE_W]  = dac_q;
    assign gain_flat[c*GAIN_W +: GAIN_W] = gn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_bits <= '0;
    end else if (wr_en && (f.sel == SEL_FUNC) && ({f.bcast, f.chan} == FUNC_CTL)) begin
      fn_bits <= f.payload[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req <= 1'b0;
      rd_hdr <= '0;
    end else if (frm_commit && f.rd) begin
      rd_req <= 1'b1;
      rd_hdr <= frm_word[FRAME_W-1 -: HDR_W];
    end else if (frm_start) begin
      rd_req <= 1'b0;
    end
  end

  assign rd_sel = rd_hdr[6:4];
  assign rd_ch  = rd_hdr[2] ? 2'd0 : rd_hdr[1:0];

  always_comb begin
    rd_val = '0;
    case (rd_sel)
      SEL_DATA: begin
        for (int i = 0; i < NCH; i++)
          if (rd_ch == 2'(i)) rd_val = inp_flat[i*CODE_W +: CODE_W];
      end
      SEL_GAIN: begin
        for (int i = 0; i < NCH; i++)
          if (rd_ch == 2'(i))
            rd_val = {{(CODE_W-GAIN_W){gain_flat[i*GAIN_W+GAIN_W-1]}},
                      gain_flat[i*GAIN_W +: GAIN_W]};
      end
      SEL_FUNC: rd_val = {{(CODE_W-3){1'b0}}, fn_bits};
      default:  rd_val = '0;
    endcase
  end

  assign rd_word = {rd_hdr, rd_val};
endmodule

// File: rtl/dacif_outfmt.sv
module dacif_outfmt
  import dacif_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  twos_q,
  input  logic [NCH*CODE_W-1:0] dac_flat,
  output logic [NCH*CODE_W-1:0] core_code
);
  for (genvar c = 0; c < NCH; c++) begin : g_fmt
    logic [CODE_W-1:0] src, cq;
    assign src = dac_flat[c*CODE_W +: CODE_W];
    always_ff @(posedge clk) begin
      if (rst) cq <= {1'b1, {(CODE_W-1){1'b0}}};
      else     cq <= {src[CODE_W-1] ^ twos_q, src[CODE_W-2:0]};
    end
    assign core_code[c*CODE_W +: CODE_W] = cq;
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacif_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int GAIN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_frame_n,
  input  logic                  ser_din,
  output logic                  ser_dout,
  input  logic                  load_n,
  input  logic                  clear_req,
  input  logic                  twos_sel,
  output logic [NCH*CODE_W-1:0] core_code,
  output logic [NCH*GAIN_W-1:0] gain_trim,
  output logic                  gnd_adj_en
);
  logic [2:0]            ctl_s1, ctl_s2;
  logic                  load_q, clear_q, twos_q;
  logic                  frm_start, frm_commit, rd_req;
  logic [FRAME_W-1:0]    frm_word, rd_word;
  logic [2:0]            fn_bits;
  logic [NCH*CODE_W-1:0] dac_flat;

  always_ff @(posedge clk) begin
    ctl_s1 <= {twos_sel, clear_req, load_n};
    ctl_s2 <= ctl_s1;
  end
  assign load_q  = ctl_s2[0];
  assign clear_q = ctl_s2[1];
  assign twos_q  = ctl_s2[2];

  dacif_rx #(.FW(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
    .ser_din(ser_din), .daisy_en(fn_bits[1]), .rd_req(rd_req), .rd_word(rd_word),
    .frm_start(frm_start), .frm_commit(frm_commit), .frm_word(frm_word),
    .ser_dout(ser_dout)
  );

  dacif_regs #(.NCH(NCH), .GAIN_W(GAIN_W)) u_regs (
    .clk(clk), .rst(rst), .twos_q(twos_q), .load_q(load_q), .clear_q(clear_q),
    .frm_start(frm_start), .frm_commit(frm_commit), .frm_word(frm_word),
    .dac_flat(dac_flat), .gain_flat(gain_trim), .fn_bits(fn_bits),
    .rd_req(rd_req), .rd_word(rd_word)
  );

  dacif_outfmt #(.NCH(NCH)) u_fmt (
    .clk(clk), .rst(rst), .twos_q(twos_q), .dac_flat(dac_flat), .core_code(core_code)
  );

  assign gnd_adj_en = fn_bits[0];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dacif_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int GAIN_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clear_q,
  input logic                  twos_q,
  input logic                  load_q,
  input logic                  commit,
  input logic                  ser_frame_n,
  input logic [NCH*CODE_W-1:0] core_code,
  input logic [NCH*CODE_W-1:0] dac_flat,
  input logic [NCH*GAIN_W-1:0] gain_flat,
  input logic [2:0]            fn_bits
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R11
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(clear_q) && $past(clear_q, 2) && !$past(rst) && !$past(rst, 2) &&
       ($past(twos_q) == $past(twos_q, 2)))
      |-> (core_code[c*CODE_W +: CODE_W] == ($past(fn_bits[2], 2) ? {CODE_W{1'b0}} : MID)));
  end

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_q) && !$past(clear_q) && !$past(rst)) |-> $stable(dac_flat));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(commit) && !$past(rst)) |-> ($stable(gain_flat) && $stable(fn_bits)));

  // R2
  commit_end_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(ser_frame_n, 2));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.NCH(NCH), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .clear_q(clear_q), .twos_q(twos_q), .load_q(load_q),
  .commit(frm_commit), .ser_frame_n(ser_frame_n), .core_code(core_code),
  .dac_flat(dac_flat), .gain_flat(gain_trim), .fn_bits(fn_bits)
);

// File: tb/test_dual_dac_ctrl.sv
`timescale 1ns/1ps
module test_dual_dac_ctrl;
  localparam int NCH = 2;
  localparam int GW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_frame_n = 1'b1, ser_din = 1'b0;
  logic load_n = 1'b0, clear_req = 1'b0, twos_sel = 1'b0;
  logic ser_dout, gnd_adj_en;
  logic [NCH*16-1:0] core_code;
  logic [NCH*GW-1:0] gain_trim;

  int checks = 0;
  int errs   = 0;

  typedef struct { logic [23:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic        mon_arm = 1'b0;
  logic [23:0] cap = '0;
  logic [63:0] dummy;
  localparam logic [23:0] NOP = 24'h300000;

  always #2.5 clk = ~clk;

  dual_dac_ctrl #(.NCH(NCH), .GAIN_W(GW)) i_dual_dac_ctrl (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .load_n(load_n), .clear_req(clear_req),
    .twos_sel(twos_sel), .core_code(core_code), .gain_trim(gain_trim),
    .gnd_adj_en(gnd_adj_en)
  );

  function automatic logic [23:0] mkf(input logic rd, input logic [2:0] sel,
                                      input logic [2:0] ch, input logic [15:0] pl);
    return {rd, sel, 1'b0, ch, pl};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic xfer(input logic [63:0] w, input int n, output logic [63:0] got);
    got = '0;
    ser_frame_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = w[i];
      ser_clk = 1'b0;
      repeat (6) @(negedge clk);
      got[i] = ser_dout;
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
    end
    ser_clk = 1'b0;
    cap = got[23:0];
    ser_frame_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] w);
    xfer({40'h0, w}, 24, dummy);
  endtask

  // driver side of the scoreboard: request, queue the expectation, clock it out
  task automatic read_chk(input logic [23:0] req, input logic [23:0] exp, input string tag);
    wr(req);
    sbq.push_back('{exp, tag});
    mon_arm = 1'b1;
    wr(NOP);
    mon_arm = 1'b0;
  endtask

  function automatic logic [15:0] cc(input int ch);
    return core_code[ch*16 +: 16];
  endfunction

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(posedge ser_frame_n);
      if (mon_arm && sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, {8'h0, cap}, {8'h0, it.exp});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 core0 reset", cc(0), 16'h8000);
    chk("R1 core1 reset", cc(1), 16'h8000);
    chk("R1 gain reset", gain_trim, 0);
    chk("R1 dout reset", ser_dout, 0);

    // R2 R3 R4 single channel writes with load held low
    wr(mkf(0, 3'b010, 3'b000, 16'h1234));
    chk("R4 core0 write", cc(0), 16'h1234);
    chk("R3 core1 untouched", cc(1), 16'h8000);
    wr(mkf(0, 3'b010, 3'b001, 16'hBEEF));
    chk("R3 core1 write", cc(1), 16'hBEEF);
    chk("R3 core0 kept", cc(0), 16'h1234);

    // R2 short and long frames are dropped
    xfer({41'h0, mkf(0, 3'b010, 3'b000, 16'h0F0F) >> 1}, 23, dummy);
    chk("R2 short frame", cc(0), 16'h1234);
    xfer({39'h0, mkf(0, 3'b010, 3'b000, 16'h0F0F), 1'b0}, 25, dummy);
    chk("R2 long frame", cc(0), 16'h1234);

    // R5 held load
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(mkf(0, 3'b010, 3'b000, 16'h5555));
    chk("R5 held output", cc(0), 16'h1234);
    load_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 load transfer", cc(0), 16'h5555);

    // R3 broadcast
    wr(mkf(0, 3'b010, 3'b100, 16'h0101));
    chk("R3 broadcast ch0", cc(0), 16'h0101);
    chk("R3 broadcast ch1", cc(1), 16'h0101);

    // R6 gain trim
    wr(mkf(0, 3'b100, 3'b001, 16'h003D));
    chk("R6 gain ch1", gain_trim[GW +: GW], 6'h3D);
    chk("R6 gain ch0", gain_trim[0 +: GW], 6'h00);

    // R8 readback
    read_chk(mkf(1, 3'b100, 3'b001, 16'h0), 24'hC1FFFD, "R8 gain readback");
    read_chk(mkf(1, 3'b010, 3'b000, 16'h0), 24'hA00101, "R8 data readback");

    // R7 control register
    wr(mkf(0, 3'b000, 3'b010, 16'h0001));
    chk("R7 wrong address ignored", gnd_adj_en, 0);
    wr(mkf(0, 3'b000, 3'b001, 16'h0001));
    chk("R7 ground adjust", gnd_adj_en, 1);
    read_chk(mkf(1, 3'b000, 3'b001, 16'h0), 24'h810001, "R8 control readback");

    // R11 clear, both codes
    clear_req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 clear mid ch0", cc(0), 16'h8000);
    chk("R11 clear mid ch1", cc(1), 16'h8000);
    clear_req = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 release clear", cc(0), 16'h0101);
    wr(mkf(0, 3'b000, 3'b001, 16'h0005));
    clear_req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 clear negative", cc(1), 16'h0000);
    clear_req = 1'b0;
    repeat (8) @(negedge clk);

    // R10 two's-complement coding
    twos_sel = 1'b1;
    repeat (4) @(negedge clk);
    wr(mkf(0, 3'b010, 3'b000, 16'h0000));
    wr(mkf(0, 3'b010, 3'b001, 16'h7FFF));
    chk("R10 twos zero", cc(0), 16'h8000);
    chk("R10 twos max", cc(1), 16'hFFFF);
    twos_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 binary pass", cc(1), 16'h7FFF);

    // R9 chain mode
    wr(mkf(0, 3'b000, 3'b001, 16'h0002));
    wr(24'h3A5C3C);
    sbq.push_back('{24'h3A5C3C, "R9 chain pass-through"});
    mon_arm = 1'b1;
    wr(mkf(0, 3'b010, 3'b000, 16'h2222));
    mon_arm = 1'b0;
    chk("R9 chain write", cc(0), 16'h2222);
    xfer({16'h0, NOP, mkf(0, 3'b010, 3'b001, 16'h3333)}, 48, dummy);
    chk("R9 chain long frame", cc(1), 16'h3333);

    // R1 reset while two's complement selected
    twos_sel = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 twos reset core", cc(0), 16'h8000);
    read_chk(mkf(1, 3'b010, 3'b000, 16'h0), 24'hA00000, "R1 twos reset data");
    chk("R9 idle dout", ser_dout, 0);

    finish_run();
  end
endmodule